// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the test access port of a small chip with a few general-purpose pins. A board tester drives the serial test clock, mode select and data input. A sixteen-state controller follows the mode-select line. A four-bit instruction register picks which data register sits between the serial input and the serial output. Four data registers can be selected:

- a one-bit bypass stage;
- a 32-bit identification word;
- a one-bit core-reset stage;
- a boundary chain with three cells per pin: output value, output enable and input value.

All of the logic runs on the test clock alone. It works when the system clock is stopped or slower than the test clock.

On its pin side the block sits between the core and the pad drivers. In functional use the core's output values and enables pass straight to the pads. Under the external-test instruction, update latches that were loaded through the chain drive the pads instead. Setting the reset stage to one holds the core in reset, and in that state the core-driven enables are turned off. Two gate inputs enable the port: a fuse-level enable and a software disable. If either gate is closed, the controller is held in its reset state and the serial output stays undriven.

Top module: `bscan_tap`

## Requirements
- R1: While `trst_n` is low, the controller is in Test-Logic-Reset at once. The current instruction is IDCODE, `core_rst` is 0, `tdo_oe` is 0, and the pads follow `core_out`/`core_oe`.
- R2: After reset, the first data scan returns the 32-bit identification word, least significant bit first. Bit 0 is 1, bits 11:1 are the manufacturer field, bits 27:12 are the part field and bits 31:28 are the version field, each set by a parameter.
- R3: The instruction register is 4 bits wide. Capture-IR loads 4'b0001, which is shifted out LSB first. Opcodes are EXTEST 0000, IDCODE 0001, SAMPLE/PRELOAD 0010, reset-stage select 1100 and BYPASS 1111. The new instruction takes effect on the falling test-clock edge in Update-IR.
- R4: BYPASS places one stage between `tdi` and `tdo`. That stage captures 0, so an n-bit scan returns 0 followed by the first n-1 input bits.
- R5: Any opcode that is not listed in R3 behaves exactly as BYPASS.
- R6: SAMPLE/PRELOAD captures the boundary chain without changing the pads. Chain bit 3i holds `core_out[i]`, bit 3i+1 holds `core_oe[i]` and bit 3i+2 holds `pad_in[i]`, and bit 0 leaves first. Update-DR copies the shifted chain into the update latches.
- R7: Once EXTEST is current, from the falling edge in Update-IR onward, `pad_out[i]` and `pad_oe[i]` come from update-latch bits 3i and 3i+1.
- R8: Under EXTEST, Capture-DR samples `pad_in` into the input cells, and each Update-DR drives the newly shifted values onto the pads.
- R9: With opcode 1100, a one-bit scan writes the reset stage, and `core_rst` equals its value immediately. The value persists across later instructions until Test-Logic-Reset. While `core_rst` is 1 and EXTEST is not current, every `pad_oe` bit is 0.
- R10: Five rising test-clock edges with `tms` high reach Test-Logic-Reset from any state. That state clears the reset stage, selects IDCODE and returns the pads to the core.
- R11: When `fuse_en` is 0 or `jtag_off` is 1, the controller stays in Test-Logic-Reset, `tdo_oe` stays 0 and no instruction takes effect.
- R12: `tdo` changes on the falling test-clock edge. `tdo_oe` is 1 only during Shift-IR and Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| fuse_en | input | 1 | Non-volatile enable for the port |
| jtag_off | input | 1 | Software disable for the port |
| core_out | input | NPINS | Output values from the core |
| core_oe | input | NPINS | Output enables from the core |
| pad_in | input | NPINS | Levels received at the pads |
| tdo | output | 1 | Serial test data out |
| tdo_oe | output | 1 | Drive enable for the serial output pad |
| pad_out | output | NPINS | Values to the pad drivers |
| pad_oe | output | NPINS | Enables to the pad drivers |
| core_rst | output | 1 | Hold-in-reset request to the core |

## Verification
The assertions check four things on every clock edge:

- the serial output enable is confined to the two shift states;
- Test-Logic-Reset always carries the IDCODE instruction;
- five consecutive high mode-select edges always end in Test-Logic-Reset;
- a closed gate silences the serial output, and a core reset with external test inactive leaves every pad enable low.

Only the bench scenarios can show the values that come out of the shift paths: the identification word, the instruction capture pattern, the bypass delay, the chain layout, the moment EXTEST takes the pads, and that the reset stage survives an instruction change.

// File: rtl/bscan_pkg.sv
// Shared types for the boundary-scan test port.
// Assumes a 4-bit instruction register; opcode values are fixed here.
package bscan_pkg;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    localparam int IR_W = 4;
    typedef logic [IR_W-1:0] op_t;

    localparam op_t OP_EXTEST = 4'b0000;
    localparam op_t OP_IDCODE = 4'b0001;
    localparam op_t OP_SAMPLE = 4'b0010;
    localparam op_t OP_RSTREG = 4'b1100;
    localparam op_t OP_BYPASS = 4'b1111;
    localparam op_t IR_CAPT   = 4'b0001;

    typedef enum logic [1:0] {
        DR_BYP, DR_ID, DR_RST, DR_BSC
    } dr_sel_e;

endpackage

// File: rtl/tap_fsm.sv
// Sixteen-state test controller advanced by tms on rising tck.
// Assumes trst_n is asynchronous; a closed enable gate pins it in Test-Logic-Reset.
module tap_fsm
    import bscan_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    input  logic       tap_ok,
    output tap_state_e state
);

    tap_state_e nxt;

    // Next-state function of the standard controller graph.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
            ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_RTI;
            default:   nxt = ST_TLR;
        endcase
    end

    // State register with asynchronous test reset and enable gate.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)     state <= ST_TLR;
        else if (!tap_ok) state <= ST_TLR;
        else             state <= nxt;
    end

endmodule

// File: rtl/tap_ir.sv
// Instruction shift stage, current-instruction latch and data-register decoder.
// Shifts on rising tck; the current instruction changes on falling tck.
module tap_ir
    import bscan_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tdi,
    input  tap_state_e state,
    output op_t        ir_cur,
    output dr_sel_e    sel,
    output logic       extest,
    output logic       ir_lsb
);

    op_t ir_sr;

    // Capture the fixed pattern or shift toward bit 0.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                ir_sr <= IR_CAPT;
        else if (state == ST_CAP_IR) ir_sr <= IR_CAPT;
        else if (state == ST_SH_IR)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end

    // Load the current instruction in Update-IR; force IDCODE in Test-Logic-Reset.
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n)                 ir_cur <= OP_IDCODE;
        else if (state == ST_TLR)    ir_cur <= OP_IDCODE;
        else if (state == ST_UPD_IR) ir_cur <= ir_sr;
    end

    // Map opcodes to data registers; unknown opcodes select bypass.
    always_comb begin
        unique case (ir_cur)
            OP_EXTEST, OP_SAMPLE: sel = DR_BSC;
            OP_IDCODE:            sel = DR_ID;
            OP_RSTREG:            sel = DR_RST;
            default:              sel = DR_BYP;
        endcase
    end

    assign extest = (ir_cur == OP_EXTEST);
    assign ir_lsb = ir_sr[0];

endmodule

// File: rtl/bscan_chain.sv
// Boundary chain: three cells per pin (value, enable, input) plus update latches.
// Cell 3i = output value, 3i+1 = output enable, 3i+2 = input level; bit 0 leaves first.
module bscan_chain #(
    parameter int NPINS = 4
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tdi,
    input  logic             cap,
    input  logic             shf,
    input  logic             upd,
    input  logic [NPINS-1:0] core_out,
    input  logic [NPINS-1:0] core_oe,
    input  logic [NPINS-1:0] pad_in,
    output logic             so,
    output logic [NPINS-1:0] upd_out,
    output logic [NPINS-1:0] upd_oe
);

    localparam int LEN = 3 * NPINS;

    logic [LEN-1:0] sr;
    logic [LEN-1:0] cap_vec;
    logic [LEN-1:0] upd_q;

    // Route each pin's three captured signals and latched controls.
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        assign cap_vec[3*i]   = core_out[i];
        assign cap_vec[3*i+1] = core_oe[i];
        assign cap_vec[3*i+2] = pad_in[i];
        assign upd_out[i]     = upd_q[3*i];
        assign upd_oe[i]      = upd_q[3*i+1];
    end

    // Capture the pin states or shift toward bit 0.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)  sr <= '0;
        else if (cap) sr <= cap_vec;
        else if (shf) sr <= {tdi, sr[LEN-1:1]};
    end

    // Copy the chain into the update latches on falling tck in Update-DR.
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n)  upd_q <= '0;
        else if (upd) upd_q <= sr;
    end

    assign so = sr[0];

endmodule

// File: rtl/bscan_tap.sv
// Top of the boundary-scan test port: controller, instruction logic, bypass,
// identification, core-reset stage, boundary chain, TDO path and pad muxing.
// Assumes all test logic runs on tck only; the system clock may be stopped.
module bscan_tap
    import bscan_pkg::*;
#(
    parameter int          NPINS    = 4,
    parameter logic [10:0] MFR_ID   = 11'h2A5,
    parameter logic [15:0] PART_ID  = 16'hB37C,
    parameter logic [3:0]  VER_ID   = 4'h6
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tms,
    input  logic             tdi,
    input  logic             fuse_en,
    input  logic             jtag_off,
    input  logic [NPINS-1:0] core_out,
    input  logic [NPINS-1:0] core_oe,
    input  logic [NPINS-1:0] pad_in,
    output logic             tdo,
    output logic             tdo_oe,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    output logic             core_rst
);

    localparam int          ID_W   = 32;
    localparam logic [ID_W-1:0] ID_VAL = {VER_ID, PART_ID, MFR_ID, 1'b1};

    tap_state_e       fsm_state;
    op_t              ir_cur;
    dr_sel_e          sel;
    logic             extest;
    logic             ir_lsb;
    logic             tap_ok;
    logic             cap_dr, sh_dr, upd_dr;
    logic             byp_q;
    logic [ID_W-1:0]  id_sr;
    logic             rst_q;
    logic             bsc_so;
    logic             dr_bit;
    logic             so_nxt;
    logic [NPINS-1:0] upd_out, upd_oe;

    assign tap_ok = fuse_en & ~jtag_off;
    assign cap_dr = (fsm_state == ST_CAP_DR);
    assign sh_dr  = (fsm_state == ST_SH_DR);
    assign upd_dr = (fsm_state == ST_UPD_DR);

    tap_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .tap_ok (tap_ok),
        .state  (fsm_state)
    );

    tap_ir u_ir (
        .tck    (tck),
        .trst_n (trst_n),
        .tdi    (tdi),
        .state  (fsm_state),
        .ir_cur (ir_cur),
        .sel    (sel),
        .extest (extest),
        .ir_lsb (ir_lsb)
    );

    bscan_chain #(.NPINS(NPINS)) u_chain (
        .tck      (tck),
        .trst_n   (trst_n),
        .tdi      (tdi),
        .cap      (cap_dr & (sel == DR_BSC)),
        .shf      (sh_dr  & (sel == DR_BSC)),
        .upd      (upd_dr & (sel == DR_BSC)),
        .core_out (core_out),
        .core_oe  (core_oe),
        .pad_in   (pad_in),
        .so       (bsc_so),
        .upd_out  (upd_out),
        .upd_oe   (upd_oe)
    );

    // Bypass stage: captures 0, then passes tdi with one cycle of delay.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                       byp_q <= 1'b0;
        else if (cap_dr && sel == DR_BYP)  byp_q <= 1'b0;
        else if (sh_dr  && sel == DR_BYP)  byp_q <= tdi;
    end

    // Identification register: loads the fixed word, shifts toward bit 0.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                      id_sr <= ID_VAL;
        else if (cap_dr && sel == DR_ID)  id_sr <= ID_VAL;
        else if (sh_dr  && sel == DR_ID)  id_sr <= {tdi, id_sr[ID_W-1:1]};
    end

    // Core-reset stage: written by shifting, cleared in Test-Logic-Reset.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                      rst_q <= 1'b0;
        else if (fsm_state == ST_TLR)     rst_q <= 1'b0;
        else if (sh_dr && sel == DR_RST)  rst_q <= tdi;
    end

    // Pick the serial bit of the selected data register.
    always_comb begin
        unique case (sel)
            DR_ID:   dr_bit = id_sr[0];
            DR_RST:  dr_bit = rst_q;
            DR_BSC:  dr_bit = bsc_so;
            default: dr_bit = byp_q;
        endcase
        so_nxt = (fsm_state == ST_SH_IR) ? ir_lsb : dr_bit;
    end

    // Serial output and its enable change on falling tck.
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo    <= so_nxt;
            tdo_oe <= tap_ok && (fsm_state == ST_SH_IR || fsm_state == ST_SH_DR);
        end
    end

    // Pad control: EXTEST latches take over, else the core, muted while in reset.
    always_comb begin
        if (extest) begin
            pad_out = upd_out;
            pad_oe  = upd_oe;
        end else begin
            pad_out = core_out;
            pad_oe  = rst_q ? '0 : core_oe;
        end
    end

    assign core_rst = rst_q;

endmodule

// File: rtl/bscan_tap_chk.sv
// Property checker for bscan_tap, bound to every instance of it.
// Observes the controller state and current instruction through the bind.
module bscan_tap_chk
    import bscan_pkg::*;
#(
    parameter int NPINS = 4
) (
    input logic             tck,
    input logic             trst_n,
    input logic             tms,
    input logic             tap_ok,
    input tap_state_e       state,
    input op_t              ir_cur,
    input logic             extest,
    input logic             tdo_oe,
    input logic             core_rst,
    input logic [NPINS-1:0] pad_oe
);

    logic [2:0] hi_cnt;

    // Count consecutive rising edges with tms high, saturating at five.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)         hi_cnt <= '0;
        else if (!tms)       hi_cnt <= '0;
        else if (hi_cnt != 3'd5) hi_cnt <= hi_cnt + 3'd1;
    end

    assert_tdo_only_shift_R12: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe |-> (state == ST_SH_IR || state == ST_SH_DR));

    assert_tlr_idcode_R10: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_TLR) |-> (ir_cur == OP_IDCODE));

    assert_five_tms_R10: assert property (@(posedge tck) disable iff (!trst_n)
        (hi_cnt == 3'd5) |-> (state == ST_TLR));

    assert_gate_quiet_R11: assert property (@(posedge tck) disable iff (!trst_n)
        !tap_ok |=> !tdo_oe);

    assert_rst_hiz_R9: assert property (@(posedge tck) disable iff (!trst_n)
        (core_rst && !extest) |-> (pad_oe == '0));

endmodule

bind bscan_tap bscan_tap_chk #(.NPINS(NPINS)) u_chk (
    .tck      (tck),
    .trst_n   (trst_n),
    .tms      (tms),
    .tap_ok   (tap_ok),
    .state    (fsm_state),
    .ir_cur   (ir_cur),
    .extest   (extest),
    .tdo_oe   (tdo_oe),
    .core_rst (core_rst),
    .pad_oe   (pad_oe)
);

// File: tb/sim_bscan_tap.sv
`timescale 1ns/1ps
// Scoreboard bench: scan tasks push expected TDO bits, a monitor pops and compares.
module sim_bscan_tap;

    localparam int N = 4;
    localparam logic [31:0] ID = {4'h6, 16'hB37C, 11'h2A5, 1'b1};

    logic tck = 1'b0;
    logic trst_n, tms, tdi, fuse_en, jtag_off;
    logic [N-1:0] core_out, core_oe, pad_in;
    logic tdo, tdo_oe, core_rst;
    logic [N-1:0] pad_out, pad_oe;

    int n_cmp = 0;
    int n_bad = 0;
    bit exp_q[$];
    string tag_q[$];

    always #2 tck = ~tck;

    bscan_tap #(.NPINS(N)) u0 (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
        .fuse_en(fuse_en), .jtag_off(jtag_off),
        .core_out(core_out), .core_oe(core_oe), .pad_in(pad_in),
        .tdo(tdo), .tdo_oe(tdo_oe), .pad_out(pad_out), .pad_oe(pad_oe),
        .core_rst(core_rst)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Monitor: every shifted TDO bit is matched against the scoreboard.
    initial begin
        forever begin
            @(negedge tck);
            #0.5;
            if (tdo_oe === 1'b1) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R12 unexpected tdo", {63'd0, tdo}, 64'd0);
                end else begin
                    bit e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(tdo === e, t, {63'd0, tdo}, {63'd0, e});
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    task automatic step(input logic m, input logic d);
        tms = m;
        tdi = d;
        @(negedge tck);
        #1;
    endtask

    task automatic push(input int n, input logic [63:0] v, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(v[i]);
            tag_q.push_back(tag);
        end
    endtask

    // From Run-Test/Idle to Update-IR, shifting opcode v.
    task automatic scan_ir(input logic [3:0] v, input string tag);
        push(4, 64'h1, tag);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 4; i++) step(i == 3, v[i]);
        step(1, 0);
    endtask

    // From Run-Test/Idle to Update-DR, shifting n bits.
    task automatic scan_dr(input int n, input logic [63:0] din, input logic [63:0] dexp, input string tag);
        push(n, dexp, tag);
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < n; i++) step(i == n - 1, din[i]);
        step(1, 0);
    endtask

    function automatic logic [63:0] mk(input logic [N-1:0] o, input logic [N-1:0] e, input logic [N-1:0] p);
        logic [63:0] r = '0;
        for (int i = 0; i < N; i++) begin
            r[3*i]   = o[i];
            r[3*i+1] = e[i];
            r[3*i+2] = p[i];
        end
        return r;
    endfunction

    initial begin
        logic [63:0] pre, nxt;
        trst_n = 0; tms = 1; tdi = 0; fuse_en = 1; jtag_off = 0;
        core_out = 4'b1010; core_oe = 4'b0110; pad_in = 4'b0011;
        #10;
        @(negedge tck); #1;
        chk(tdo_oe == 0 && core_rst == 0, "R1 reset tdo_oe/core_rst", {tdo_oe, core_rst}, 0);
        chk(pad_out == core_out && pad_oe == core_oe, "R1 pads follow core", {pad_out, pad_oe}, {core_out, core_oe});
        trst_n = 1;
        step(0, 0);
        chk(tdo_oe == 0, "R12 no drive in idle", tdo_oe, 0);

        // R2: first data scan returns the identification word.
        scan_dr(32, 64'd0, {32'd0, ID}, "R2 idcode"); step(0, 0);

        // R3/R4: bypass opcode, capture pattern and one-stage delay.
        scan_ir(4'b1111, "R3 ir capture"); step(0, 0);
        scan_dr(8, 64'hB6, {56'd0, 7'h36, 1'b0}, "R4 bypass"); step(0, 0);

        // R5: undefined opcode behaves as bypass.
        scan_ir(4'b0101, "R3 ir capture"); step(0, 0);
        scan_dr(8, 64'h5D, {56'd0, 7'h5D, 1'b0}, "R5 undefined as bypass"); step(0, 0);

        // R6: sample and preload.
        scan_ir(4'b0010, "R3 ir capture"); step(0, 0);
        pre = mk(4'b0101, 4'b1111, 4'b0000);
        scan_dr(12, pre, mk(core_out, core_oe, pad_in), "R6 sample capture");
        chk(pad_out == core_out && pad_oe == core_oe, "R6 pads undisturbed", {pad_out, pad_oe}, {core_out, core_oe});
        step(0, 0);

        // R7: EXTEST drives preloaded values from Update-IR.
        scan_ir(4'b0000, "R3 ir capture");
        chk(pad_out == 4'b0101 && pad_oe == 4'b1111, "R7 extest at update-ir", {pad_out, pad_oe}, {4'b0101, 4'b1111});
        step(0, 0);

        // R8: EXTEST capture of pad inputs and update of outputs.
        pad_in = 4'b1100;
        nxt = mk(4'b0011, 4'b1001, 4'b0000);
        scan_dr(12, nxt, mk(core_out, core_oe, 4'b1100), "R8 extest capture");
        chk(pad_out == 4'b0011 && pad_oe == 4'b1001, "R8 extest update", {pad_out, pad_oe}, {4'b0011, 4'b1001});
        step(0, 0);

        // R9: reset stage.
        scan_ir(4'b1100, "R3 ir capture"); step(0, 0);
        chk(pad_oe == core_oe, "R9 pads back to core", pad_oe, core_oe);
        scan_dr(1, 64'd1, 64'd0, "R9 reset stage out");
        chk(core_rst == 1 && pad_oe == 0, "R9 reset asserts, pads off", {core_rst, pad_oe}, {1'b1, 4'b0000});
        step(0, 0);
        scan_dr(1, 64'd0, 64'd1, "R9 reset stage out");
        chk(core_rst == 0 && pad_oe == core_oe, "R9 reset released", {core_rst, pad_oe}, {1'b0, core_oe});
        step(0, 0);
        scan_dr(1, 64'd1, 64'd0, "R9 reset stage out"); step(0, 0);
        scan_ir(4'b1111, "R3 ir capture"); step(0, 0);
        chk(core_rst == 1 && pad_oe == 0, "R9 reset persists", {core_rst, pad_oe}, {1'b1, 4'b0000});

        // R10: five tms-high edges.
        for (int i = 0; i < 5; i++) step(1, 0);
        chk(core_rst == 0 && pad_oe == core_oe && pad_out == core_out, "R10 tlr releases",
            {core_rst, pad_oe, pad_out}, {1'b0, core_oe, core_out});
        step(0, 0);
        scan_dr(32, 64'd0, {32'd0, ID}, "R10 idcode after tlr"); step(0, 0);

        // R11: gate closed ignores an EXTEST load.
        jtag_off = 1;
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 4; i++) begin
            step(i == 3, 1'b0);
            chk(tdo_oe == 0, "R11 tdo quiet when disabled", tdo_oe, 0);
        end
        step(1, 0); step(0, 0);
        chk(pad_out == core_out && pad_oe == core_oe, "R11 instruction ignored", {pad_out, pad_oe}, {core_out, core_oe});
        jtag_off = 0; fuse_en = 0;
        step(0, 0); step(1, 0); step(0, 0); step(0, 0);
        chk(tdo_oe == 0, "R11 fuse closed", tdo_oe, 0);
        fuse_en = 1;
        step(1, 0); step(0, 0);

        chk(exp_q.size() == 0, "R12 all bits observed", exp_q.size(), 0);
        summary();
    end

endmodule